// File: doc/BRIEF.md
# Programmable static-memory cycle generator

This block produces the control timing for one chip select of an external static memory. A single-cycle start pulse requests an access. With it come the address, the write data, the byte enables and a read/write flag. Configuration inputs give the timing of each strobe as counts of clock cycles. For writes, the write strobe and the chip select each have their own setup, pulse and hold counts. For reads, the read strobe and the chip select have a second, separate set of counts.

All strobes are active low. Every access is timed from one shared cycle counter, so the strobes of one access keep a fixed relationship to the address. On a read, the input data bus is captured at an edge chosen by a mode bit. It is held on `rd_data` and announced by a one-cycle `done` pulse, which also closes every write.

Top module: `smc_cycle_gen`

## Requirements
- R1: During and after reset, with no access requested, `mem_cs_n`, `mem_we_n`, `mem_rd_n` and every bit of `mem_bwe_n` are high, and `mem_oe` and `done` are low.
- R2: The block accepts `req_start` only when it is idle. At acceptance it captures the address, write data, byte enables, direction and all timing inputs. In the first access cycle (counter value 0) `mem_addr` already shows the new address and no strobe is low. Address and write data stay stable until the access ends.
- R3: On a write, `mem_we_n` is low exactly for counter values k with S <= k < S+P. S is the effective write-strobe setup and P the effective write-strobe pulse.
- R4: `mem_cs_n` follows the same window rule. It uses the chip-select write counts on writes and the separate chip-select read counts on reads.
- R5: An access lasts the larger of the two strobe spans in use, where a span is S+P+hold. `done` is high for exactly one cycle, the cycle after the last access cycle.
- R6: `mem_bwe_n[i]` is low exactly when `mem_we_n` is low and byte enable bit i (bit i covers data bits 8i+7..8i) was set for the access.
- R7: `mem_oe` is high in every cycle of a write access, including the hold cycles. It is low in the cycle after the write ends and during reads. `mem_dout` shows the captured write data while `mem_oe` is high.
- R8: On a read, `mem_rd_n` follows the window rule with the read-strobe counts. `mem_we_n` and `mem_bwe_n` stay high.
- R9: With `cfg_cap_mode` = 0, `rd_data` takes the value of `mem_din` at the clock edge that ends the last cycle in which `mem_cs_n` is low.
- R10: With `cfg_cap_mode` = 1, `rd_data` takes the value of `mem_din` at the clock edge that ends the last cycle in which `mem_rd_n` is low.
- R11: A `req_start` during an access has no effect. The address does not change and no extra `done` appears.
- R12: A setup or pulse count of 0 behaves as 1. Hold counts may be 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_start | input | 1 | Access request pulse |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Access address |
| req_wdata | input | 8*NB | Write data |
| req_be | input | NB | Byte enables for writes |
| cfg_we_setup | input | TW | Write strobe setup count |
| cfg_we_pulse | input | TW | Write strobe pulse count |
| cfg_we_hold | input | TW | Write strobe hold count |
| cfg_cswr_setup | input | TW | Chip select setup count, writes |
| cfg_cswr_pulse | input | TW | Chip select pulse count, writes |
| cfg_cswr_hold | input | TW | Chip select hold count, writes |
| cfg_rd_setup | input | TW | Read strobe setup count |
| cfg_rd_pulse | input | TW | Read strobe pulse count |
| cfg_rd_hold | input | TW | Read strobe hold count |
| cfg_csrd_setup | input | TW | Chip select setup count, reads |
| cfg_csrd_pulse | input | TW | Chip select pulse count, reads |
| cfg_csrd_hold | input | TW | Chip select hold count, reads |
| cfg_cap_mode | input | 1 | Read capture point: 0 chip-select rise, 1 read-strobe rise |
| mem_addr | output | AW | Memory address bus |
| mem_dout | output | 8*NB | Memory data bus, outgoing |
| mem_oe | output | 1 | Data bus output enable |
| mem_din | input | 8*NB | Memory data bus, incoming |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_rd_n | output | 1 | Read strobe, active low |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_bwe_n | output | NB | Per-byte write strobes, active low |
| rd_data | output | 8*NB | Captured read data |
| done | output | 1 | One-cycle end-of-access pulse |

## Verification
A wrong counter value or a wrong latched count moves a strobe edge. That shows on `mem_cs_n`, `mem_we_n` or `mem_rd_n` in the very cycle the edge belongs to, so the bench compares every strobe against its own window model on every access cycle. A wrong end-of-access decision shows as `done` on the wrong cycle, or as `mem_oe` held too long or dropped during hold, by the end of that access. A wrong capture point can only be seen when `done` rises. It shows then because the bench changes `mem_din` every cycle, so each capture edge returns a distinct value.

// File: rtl/smc_pkg.sv
package smc_pkg;
   typedef enum logic {
      ACC_READ  = 1'b0,
      ACC_WRITE = 1'b1
   } acc_kind_e;

   typedef enum logic {
      CAP_CS_RISE = 1'b0,
      CAP_RD_RISE = 1'b1
   } cap_mode_e;
endpackage

// File: rtl/smc_strobe_gen.sv
module smc_strobe_gen #(
   parameter int TW = 4,
   parameter int CW = TW + 2
) (
   input  logic          en,
   input  logic [CW-1:0] cnt,
   input  logic [TW-1:0] setup,
   input  logic [TW-1:0] pulse,
   input  logic [TW-1:0] hold,
   output logic          strobe_n,
   output logic          last_low,
   output logic [CW-1:0] span
);
   logic [CW-1:0] lo, hi;

   always_comb begin
      lo       = (setup == '0) ? CW'(1) : CW'(setup);
      hi       = lo + ((pulse == '0) ? CW'(1) : CW'(pulse));
      span     = hi + CW'(hold);
      strobe_n = !(en && (cnt >= lo) && (cnt < hi));
      last_low = en && (cnt == hi - CW'(1));
   end
endmodule

// File: rtl/smc_seq_ctl.sv
module smc_seq_ctl #(
   parameter int CW = 6
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic [CW-1:0] len,
   output logic          accept,
   output logic          busy,
   output logic [CW-1:0] cnt,
   output logic          last,
   output logic          done
);
   assign accept = start && !busy;
   assign last   = busy && (cnt == len - CW'(1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy <= 1'b0;
         cnt  <= '0;
         done <= 1'b0;
      end else begin
         done <= last;
         if (accept) begin
            busy <= 1'b1;
            cnt  <= '0;
         end else if (last) begin
            busy <= 1'b0;
            cnt  <= '0;
         end else if (busy) begin
            cnt  <= cnt + CW'(1);
         end
      end
   end
endmodule

// File: rtl/smc_cycle_gen.sv
module smc_cycle_gen
   import smc_pkg::*;
#(
   parameter int AW         = 24,
   parameter int NB         = 4,
   parameter int TW         = 4,
   parameter bit BYTE_WRITE = 1'b1,
   localparam int DW        = 8 * NB,
   localparam int CW        = TW + 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          req_start,
   input  logic          req_write,
   input  logic [AW-1:0] req_addr,
   input  logic [DW-1:0] req_wdata,
   input  logic [NB-1:0] req_be,
   input  logic [TW-1:0] cfg_we_setup,
   input  logic [TW-1:0] cfg_we_pulse,
   input  logic [TW-1:0] cfg_we_hold,
   input  logic [TW-1:0] cfg_cswr_setup,
   input  logic [TW-1:0] cfg_cswr_pulse,
   input  logic [TW-1:0] cfg_cswr_hold,
   input  logic [TW-1:0] cfg_rd_setup,
   input  logic [TW-1:0] cfg_rd_pulse,
   input  logic [TW-1:0] cfg_rd_hold,
   input  logic [TW-1:0] cfg_csrd_setup,
   input  logic [TW-1:0] cfg_csrd_pulse,
   input  logic [TW-1:0] cfg_csrd_hold,
   input  logic          cfg_cap_mode,
   output logic [AW-1:0] mem_addr,
   output logic [DW-1:0] mem_dout,
   output logic          mem_oe,
   input  logic [DW-1:0] mem_din,
   output logic          mem_cs_n,
   output logic          mem_rd_n,
   output logic          mem_we_n,
   output logic [NB-1:0] mem_bwe_n,
   output logic [DW-1:0] rd_data,
   output logic          done
);
   if (TW < 2 || TW > 8) begin : g_bad_tw
      $error("smc_cycle_gen: TW must lie in 2..8");
   end
   if (NB != 1 && NB != 2 && NB != 4) begin : g_bad_nb
      $error("smc_cycle_gen: NB must be 1, 2 or 4");
   end
   if (AW < 1) begin : g_bad_aw
      $error("smc_cycle_gen: AW must be positive");
   end

   // request and timing snapshot taken at acceptance
   acc_kind_e     kind_q;
   cap_mode_e     cap_q;
   logic [AW-1:0] addr_q;
   logic [DW-1:0] wdata_q, rdata_q;
   logic [NB-1:0] be_q;
   logic [TW-1:0] we_s_q, we_p_q, we_h_q, rd_s_q, rd_p_q, rd_h_q;
   logic [TW-1:0] cw_s_q, cw_p_q, cw_h_q, cr_s_q, cr_p_q, cr_h_q;

   logic          seq_accept, seq_busy, seq_last;
   logic [CW-1:0] seq_cnt, seq_len;
   logic          is_wr;
   logic          we_en, rd_en;
   logic          we_last, rd_last, cs_last;
   logic [CW-1:0] we_span, rd_span, cs_span, dat_span;
   logic          cap_hit;

   assign is_wr = (kind_q == ACC_WRITE);
   assign we_en = seq_busy && is_wr;
   assign rd_en = seq_busy && !is_wr;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         kind_q  <= ACC_READ;
         cap_q   <= CAP_CS_RISE;
         addr_q  <= '0;
         wdata_q <= '0;
         be_q    <= '0;
         we_s_q  <= '0; we_p_q <= '0; we_h_q <= '0;
         rd_s_q  <= '0; rd_p_q <= '0; rd_h_q <= '0;
         cw_s_q  <= '0; cw_p_q <= '0; cw_h_q <= '0;
         cr_s_q  <= '0; cr_p_q <= '0; cr_h_q <= '0;
      end else if (seq_accept) begin
         kind_q  <= req_write ? ACC_WRITE : ACC_READ;
         cap_q   <= cfg_cap_mode ? CAP_RD_RISE : CAP_CS_RISE;
         addr_q  <= req_addr;
         wdata_q <= req_wdata;
         be_q    <= req_be;
         we_s_q  <= cfg_we_setup;   we_p_q <= cfg_we_pulse;   we_h_q <= cfg_we_hold;
         rd_s_q  <= cfg_rd_setup;   rd_p_q <= cfg_rd_pulse;   rd_h_q <= cfg_rd_hold;
         cw_s_q  <= cfg_cswr_setup; cw_p_q <= cfg_cswr_pulse; cw_h_q <= cfg_cswr_hold;
         cr_s_q  <= cfg_csrd_setup; cr_p_q <= cfg_csrd_pulse; cr_h_q <= cfg_csrd_hold;
      end
   end

   smc_seq_ctl #(.CW(CW)) i_seq (
      .clk    (clk),
      .rst_n  (rst_n),
      .start  (req_start),
      .len    (seq_len),
      .accept (seq_accept),
      .busy   (seq_busy),
      .cnt    (seq_cnt),
      .last   (seq_last),
      .done   (done)
   );

   smc_strobe_gen #(.TW(TW), .CW(CW)) i_we_gen (
      .en (we_en), .cnt (seq_cnt),
      .setup (we_s_q), .pulse (we_p_q), .hold (we_h_q),
      .strobe_n (mem_we_n), .last_low (we_last), .span (we_span)
   );

   smc_strobe_gen #(.TW(TW), .CW(CW)) i_rd_gen (
      .en (rd_en), .cnt (seq_cnt),
      .setup (rd_s_q), .pulse (rd_p_q), .hold (rd_h_q),
      .strobe_n (mem_rd_n), .last_low (rd_last), .span (rd_span)
   );

   smc_strobe_gen #(.TW(TW), .CW(CW)) i_cs_gen (
      .en (seq_busy), .cnt (seq_cnt),
      .setup (is_wr ? cw_s_q : cr_s_q),
      .pulse (is_wr ? cw_p_q : cr_p_q),
      .hold  (is_wr ? cw_h_q : cr_h_q),
      .strobe_n (mem_cs_n), .last_low (cs_last), .span (cs_span)
   );

   assign dat_span = is_wr ? we_span : rd_span;
   assign seq_len  = (dat_span > cs_span) ? dat_span : cs_span;

   assign cap_hit = rd_en && ((cap_q == CAP_RD_RISE) ? rd_last : cs_last);

   always_ff @(posedge clk) begin
      if (!rst_n)       rdata_q <= '0;
      else if (cap_hit) rdata_q <= mem_din;
   end

   if (BYTE_WRITE) begin : g_byte_we
      for (genvar gi = 0; gi < NB; gi++) begin : g_lane
         assign mem_bwe_n[gi] = mem_we_n | ~be_q[gi];
      end
   end else begin : g_word_we
      assign mem_bwe_n = {NB{mem_we_n}};
   end

   assign mem_addr = addr_q;
   assign mem_dout = wdata_q;
   assign mem_oe   = we_en;
   assign rd_data  = rdata_q;
endmodule

// File: rtl/smc_cycle_chk.sv
module smc_cycle_chk #(
   parameter int AW = 24,
   parameter int NB = 4
) (
   input logic          clk,
   input logic          rst_n,
   input logic          req_start,
   input logic          seq_busy,
   input logic [AW-1:0] mem_addr,
   input logic          mem_oe,
   input logic          mem_cs_n,
   input logic          mem_rd_n,
   input logic          mem_we_n,
   input logic [NB-1:0] mem_bwe_n,
   input logic          done
);
   p_first_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (req_start && !seq_busy) |=> (mem_cs_n && mem_we_n && mem_rd_n));

   p_addr_held_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (seq_busy && $past(seq_busy)) |-> $stable(mem_addr));

   p_cs_in_access_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_cs_n |-> seq_busy);

   p_done_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   p_bwe_under_we_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_bwe_n != {NB{1'b1}}) |-> !mem_we_n);

   p_we_drives_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_we_n |-> mem_oe);

   p_rd_floats_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_rd_n |-> (!mem_oe && mem_we_n));
endmodule

bind smc_cycle_gen smc_cycle_chk #(.AW(AW), .NB(NB)) i_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_start (req_start),
   .seq_busy  (seq_busy),
   .mem_addr  (mem_addr),
   .mem_oe    (mem_oe),
   .mem_cs_n  (mem_cs_n),
   .mem_rd_n  (mem_rd_n),
   .mem_we_n  (mem_we_n),
   .mem_bwe_n (mem_bwe_n),
   .done      (done)
);

// File: tb/test_smc_cycle_gen.sv
module test_smc_cycle_gen;
   localparam int CLK_PERIOD = 10;
   localparam int AW = 24, NB = 4, TW = 4, DW = 32;

   logic clk = 1'b0, rst_n = 1'b0;
   logic req_start = 1'b0, req_write = 1'b0, cfg_cap_mode = 1'b0;
   logic [AW-1:0] req_addr = '0;
   logic [DW-1:0] req_wdata = '0, mem_din = '0;
   logic [NB-1:0] req_be = '0;
   logic [TW-1:0] c_we[3], c_cw[3], c_rd[3], c_cr[3];
   logic [AW-1:0] mem_addr;
   logic [DW-1:0] mem_dout, rd_data;
   logic mem_oe, mem_cs_n, mem_rd_n, mem_we_n, done;
   logic [NB-1:0] mem_bwe_n;

   int tests = 0, fails = 0, cyc = 0;

   typedef struct { bit rd; logic [31:0] data; int at; } item_t;
   item_t sq[$];

   always #(CLK_PERIOD/2) clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   smc_cycle_gen #(.AW(AW), .NB(NB), .TW(TW), .BYTE_WRITE(1'b1)) i_smc_cycle_gen (
      .clk, .rst_n, .req_start, .req_write, .req_addr, .req_wdata, .req_be,
      .cfg_we_setup (c_we[0]), .cfg_we_pulse (c_we[1]), .cfg_we_hold (c_we[2]),
      .cfg_cswr_setup (c_cw[0]), .cfg_cswr_pulse (c_cw[1]), .cfg_cswr_hold (c_cw[2]),
      .cfg_rd_setup (c_rd[0]), .cfg_rd_pulse (c_rd[1]), .cfg_rd_hold (c_rd[2]),
      .cfg_csrd_setup (c_cr[0]), .cfg_csrd_pulse (c_cr[1]), .cfg_csrd_hold (c_cr[2]),
      .cfg_cap_mode, .mem_addr, .mem_dout, .mem_oe, .mem_din,
      .mem_cs_n, .mem_rd_n, .mem_we_n, .mem_bwe_n, .rd_data, .done
   );

   task automatic check(input bit ok, input string req, input longint act, input longint exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic int eff(input int v); return (v == 0) ? 1 : v; endfunction
   function automatic bit in_win(input int k, input int s, input int p);
      return (k >= eff(s)) && (k < eff(s) + eff(p));
   endfunction
   function automatic int span(input int s, input int p, input int h);
      return eff(s) + eff(p) + h;
   endfunction
   function automatic logic [31:0] pat(input int k); return 32'hC0DE_0000 + k; endfunction

   task automatic set_cfg(input int we[3], input int cw[3], input int rd[3], input int cr[3], input bit mode);
      for (int i = 0; i < 3; i++) begin
         c_we[i] = TW'(we[i]); c_cw[i] = TW'(cw[i]);
         c_rd[i] = TW'(rd[i]); c_cr[i] = TW'(cr[i]);
      end
      cfg_cap_mode = mode;
   endtask

   // driver: pushes the expected end-of-access item and compares the strobe waveform per cycle
   task automatic access(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] wd,
                         input logic [NB-1:0] be, input bit poke);
      int s[3], len, cap, nbad[7];
      longint av[7], ev[7];
      string nm[7];
      item_t it;
      nm = '{"R4 chip select", "R3 write strobe", "R6 byte strobes", "R7 output enable",
             "R2 address", "R8 read strobe", "R2 write data"};
      for (int i = 0; i < 3; i++) s[i] = wr ? int'(c_cw[i]) : int'(c_cr[i]);
      if (wr) len = span(c_we[0], c_we[1], c_we[2]);
      else    len = span(c_rd[0], c_rd[1], c_rd[2]);
      if (span(s[0], s[1], s[2]) > len) len = span(s[0], s[1], s[2]);
      if (cfg_cap_mode) cap = eff(c_rd[0]) + eff(c_rd[1]) - 1;
      else              cap = eff(c_cr[0]) + eff(c_cr[1]) - 1;
      foreach (nbad[i]) nbad[i] = 0;
      @(negedge clk);
      req_write = wr; req_addr = a; req_wdata = wd; req_be = be; req_start = 1'b1;
      it.rd = !wr; it.data = pat(cap); it.at = cyc + 1 + len;
      sq.push_back(it);
      for (int k = 0; k < len; k++) begin
         bit wl;
         logic [NB-1:0] eb;
         @(negedge clk);
         req_start = poke && (k == 1);
         if (poke && k == 1) req_addr = ~a;
         mem_din = pat(k);
         wl = wr && in_win(k, c_we[0], c_we[1]);
         eb = wl ? ~be : '1;
         if (mem_cs_n !== !in_win(k, s[0], s[1]) && nbad[0]++ == 0) begin av[0] = mem_cs_n; ev[0] = !in_win(k, s[0], s[1]); end
         if (mem_we_n !== !wl && nbad[1]++ == 0) begin av[1] = mem_we_n; ev[1] = !wl; end
         if (mem_bwe_n !== eb && nbad[2]++ == 0) begin av[2] = mem_bwe_n; ev[2] = eb; end
         if (mem_oe !== wr && nbad[3]++ == 0) begin av[3] = mem_oe; ev[3] = wr; end
         if (mem_addr !== a && nbad[4]++ == 0) begin av[4] = mem_addr; ev[4] = a; end
         if (mem_rd_n !== !(!wr && in_win(k, c_rd[0], c_rd[1])) && nbad[5]++ == 0) begin
            av[5] = mem_rd_n; ev[5] = !(!wr && in_win(k, c_rd[0], c_rd[1])); end
         if (wr && mem_dout !== wd && nbad[6]++ == 0) begin av[6] = mem_dout; ev[6] = wd; end
      end
      for (int i = 0; i < 7; i++) check(nbad[i] == 0, nm[i], av[i], ev[i]);
      @(negedge clk);
      req_start = 1'b0;
      // R7: bus released and strobes idle after the last hold cycle
      check(!mem_oe && mem_cs_n && mem_we_n && mem_rd_n, "R7 release after access",
            {mem_oe, mem_cs_n, mem_we_n, mem_rd_n}, 4'b0111);
   endtask

   // monitor: pops expected items when the design signals completion
   always @(negedge clk) begin
      if (rst_n && done) begin
         if (sq.size() == 0) begin
            check(1'b0, "R11 unexpected done", 1, 0);
         end else begin
            item_t it;
            it = sq.pop_front();
            check(cyc == it.at, "R5 done cycle", cyc, it.at);
            if (it.rd) check(rd_data === it.data,
                             cfg_cap_mode ? "R10 capture at read-strobe rise" : "R9 capture at chip-select rise",
                             rd_data, it.data);
         end
      end
   end

   initial begin
      #(CLK_PERIOD * 20000);
      check(1'b0, "watchdog", cyc, 0);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      set_cfg('{2,3,1}, '{1,5,2}, '{2,2,1}, '{1,5,1}, 1'b0);
      repeat (3) @(negedge clk);
      check(mem_cs_n && mem_we_n && mem_rd_n && mem_bwe_n == '1 && !mem_oe && !done,
            "R1 reset idle", {mem_cs_n, mem_we_n, mem_rd_n, mem_oe, done}, 5'b11100);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      check(mem_cs_n && mem_we_n && mem_rd_n && mem_bwe_n == '1 && !mem_oe && !done,
            "R1 idle after reset", {mem_cs_n, mem_we_n, mem_rd_n, mem_oe, done}, 5'b11100);
      // write: chip select span longer than write strobe span (R3 R4 R5 R6)
      access(1'b1, 24'h12_3456, 32'hDEAD_BEEF, 4'b0101, 1'b0);
      // R12: zero setup and pulse act as one cycle
      set_cfg('{0,0,0}, '{0,0,0}, '{2,2,1}, '{1,5,1}, 1'b0);
      access(1'b1, 24'h00_0F0F, 32'h1111_2222, 4'b1111, 1'b0);
      // R9: read, capture at chip-select rise
      set_cfg('{2,3,1}, '{1,5,2}, '{2,2,1}, '{1,5,1}, 1'b0);
      access(1'b0, 24'hAB_CDEF, 32'h0, 4'b0000, 1'b0);
      // R10: same timing, capture at read-strobe rise
      set_cfg('{2,3,1}, '{1,5,2}, '{2,2,1}, '{1,5,1}, 1'b1);
      access(1'b0, 24'h55_AA55, 32'h0, 4'b0000, 1'b0);
      // R11: write-strobe span longer, start pulsed during the access
      set_cfg('{1,2,4}, '{3,1,0}, '{3,4,2}, '{1,1,1}, 1'b1);
      access(1'b1, 24'h77_0001, 32'hCAFE_F00D, 4'b1010, 1'b1);
      // read strobe span longer than chip select, both capture modes
      access(1'b0, 24'h33_3333, 32'h0, 4'b0000, 1'b0);
      set_cfg('{1,2,4}, '{3,1,0}, '{3,4,2}, '{1,1,1}, 1'b0);
      access(1'b0, 24'h44_4444, 32'h0, 4'b0000, 1'b1);
      repeat (4) @(negedge clk);
      check(sq.size() == 0, "R5 every access completed", sq.size(), 0);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule